// File: doc/BRIEF.md
# Split-Window Bank Controller with Readback Overlay

This block decodes an 8 KB host window starting at 0x6000 and turns host accesses into ROM addresses and overlay-RAM accesses. The lower 4 KB half of the window always reaches one fixed ROM slot. The upper 4 KB half reaches one of four switchable 4 KB ROM banks. The ROM address space is 32 KB, with the fixed slot at the bottom and the banks above it.

Software selects a bank by writing the bank number as an ordinary data byte to the selection address 0x6FFE. A 1 KB RAM sits over the top of the fixed half (0x6C00–0x6FFF), and the selection address lies inside it. The same write edge that loads the bank register also stores the whole byte in that RAM cell, so software reads back the current bank from the selection address without extra hardware. Host reads return RAM data in the overlay range, ROM data elsewhere in the window, and zero outside the window. Writes take effect at the rising clock edge on which `host_wr` is high. Address decode, the ROM address and the read mux are combinational.

Top module: `split_bank_ctrl`

## Requirements
- R1: For a host address outside 0x6000–0x7FFF, `rom_cs` and `ram_sel` are both 0 and `host_rdata` is 0.
- R2: For 0x6000–0x6BFF, `rom_cs` is 1 and `rom_addr` equals {3'b000, host_addr[11:0]} whatever the bank register holds.
- R3: For 0x7000–0x7FFF, `rom_cs` is 1 and `rom_addr` equals {bank + 1 as 3 bits, host_addr[11:0]}, and `host_rdata` returns `rom_rdata`.
- R4: A write to 0x6FFE loads `host_wdata[1:0]` into the bank register at that clock edge. The new bank applies to accesses from the next cycle on.
- R5: After reset the bank register is 0, so 0x7000–0x7FFF reaches ROM slot 1.
- R6: For 0x6C00–0x6FFF, `ram_sel` is 1, `rom_cs` is 0 and `host_rdata` returns the RAM byte at index host_addr[9:0]. `rom_cs` and `ram_sel` are never both 1.
- R7: A write to 0x6FFE stores all 8 data bits in the RAM on the same edge, so a later read of 0x6FFE returns the full byte written, upper bits included.
- R8: A write to any other address in 0x6C00–0x6FFF updates only that RAM byte and leaves the bank register unchanged.
- R9: Writes to 0x6000–0x6BFF, to 0x7000–0x7FFF or outside the window change neither the bank register nor any RAM byte. This holds for 0x7FFE, which shares its low ten address bits with the selection address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the bank register |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, sampled at the clock edge |
| host_rdata | output | 8 | Read data: RAM, ROM or zero |
| rom_addr | output | 15 | ROM byte address {slot, offset} |
| rom_rdata | input | 8 | Data returned by the ROM for `rom_addr` |
| rom_cs | output | 1 | Host address hits a ROM-backed part of the window |
| ram_sel | output | 1 | Host address hits the overlay RAM |

## Verification
A write to 0x6FFE drives two functions on one clock edge: the bank register load and the RAM byte store. The bench writes selection bytes whose upper bits are nonzero. In the next cycle it judges the bank load by the slot field of `rom_addr` for an address in 0x7000–0x7FFF, and the RAM store by reading 0x6FFE back as the full byte. Random traffic mixes these writes with plain RAM writes, ignored ROM writes and reads in every region. A reference model in the bench predicts every output.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {
      RG_OUTSIDE = 2'd0,
      RG_FIXED   = 2'd1,
      RG_OVERLAY = 2'd2,
      RG_BANKED  = 2'd3
   } sbc_region_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
   import sbc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int OFS_W     = 12,
   parameter int WIN_BASE  = 'h6000,
   parameter int RAM_WORDS = 1024,
   parameter int SEL_ADDR  = 'h6FFE
)(
   input  logic [ADDR_W-1:0]            addr,
   output sbc_region_e                  region,
   output logic                         sel_hit,
   output logic [$clog2(RAM_WORDS)-1:0] ram_idx
);
   localparam int          RAM_AW   = $clog2(RAM_WORDS);
   localparam int          HALF     = 1 << OFS_W;
   localparam logic [31:0] WIN_LO   = 32'(WIN_BASE);
   localparam logic [31:0] WIN_MID  = 32'(WIN_BASE + HALF);
   localparam logic [31:0] WIN_HI   = 32'(WIN_BASE + 2 * HALF);
   localparam logic [31:0] RAM_LO   = 32'(WIN_BASE + HALF - RAM_WORDS);
   localparam logic [31:0] SEL_A    = 32'(SEL_ADDR);

   logic [31:0] a32;
   logic [31:0] rel;

   assign a32     = 32'(addr);
   assign rel     = a32 - RAM_LO;
   assign ram_idx = rel[RAM_AW-1:0];
   assign sel_hit = (a32 == SEL_A);

   always_comb begin
      if (a32 < WIN_LO || a32 >= WIN_HI) begin
         region = RG_OUTSIDE;
      end else if (a32 >= WIN_MID) begin
         region = RG_BANKED;
      end else if (a32 >= RAM_LO) begin
         region = RG_OVERLAY;
      end else begin
         region = RG_FIXED;
      end
   end

   // R6: the selection address always decodes into the overlay RAM
   always_comb begin
      if (sel_hit) begin
         assert_sel_in_overlay_R6: assert (region == RG_OVERLAY);
      end
   end
endmodule

// File: rtl/sbc_bank_reg.sv
module sbc_bank_reg #(
   parameter int BANK_W = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] din,
   output logic [BANK_W-1:0] bank_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else if (load) begin
         bank_q <= din;
      end
   end

   assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bank_q == $past(din)));

   assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (bank_q == $past(bank_q)));
endmodule

// File: rtl/sbc_overlay_ram.sv
module sbc_overlay_ram #(
   parameter int DATA_W = 8,
   parameter int WORDS  = 1024
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] idx,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];

   assert_ram_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/split_bank_ctrl.sv
module split_bank_ctrl
   import sbc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int OFS_W     = 12,
   parameter int BANK_W    = 2,
   parameter int WIN_BASE  = 'h6000,
   parameter int RAM_WORDS = 1024,
   parameter int SEL_ADDR  = 'h6FFE,
   parameter bit FIXED_LOW = 1'b1,
   localparam int NUM_BANKS = 1 << BANK_W,
   localparam int SLOT_W    = $clog2(NUM_BANKS + 1),
   localparam int ROM_AW    = SLOT_W + OFS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_wr,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_rdata,
   output logic              rom_cs,
   output logic              ram_sel
);
   localparam int RAM_AW = $clog2(RAM_WORDS);
   localparam int HALF   = 1 << OFS_W;

   if (RAM_WORDS > HALF || (1 << RAM_AW) != RAM_WORDS) begin : g_bad_ram
      $error("overlay RAM must be a power of two no larger than one half window");
   end
   if (SEL_ADDR < WIN_BASE + HALF - RAM_WORDS || SEL_ADDR >= WIN_BASE + HALF) begin : g_bad_sel
      $error("selection address must lie inside the overlay RAM");
   end
   if (BANK_W < 1 || DATA_W < BANK_W || ADDR_W > 31) begin : g_bad_width
      $error("inconsistent width parameters");
   end

   sbc_region_e        region;
   logic               sel_hit;
   logic [RAM_AW-1:0]  ram_idx;
   logic [BANK_W-1:0]  bank_q;
   logic [DATA_W-1:0]  ram_rdata;
   logic [SLOT_W-1:0]  fixed_slot;
   logic [SLOT_W-1:0]  bank_slot;
   logic               bank_load;
   logic               ram_we;

   sbc_decode #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE),
      .RAM_WORDS(RAM_WORDS), .SEL_ADDR(SEL_ADDR)
   ) i_decode (
      .addr(host_addr), .region(region), .sel_hit(sel_hit), .ram_idx(ram_idx)
   );

   assign rom_cs    = (region == RG_FIXED) || (region == RG_BANKED);
   assign ram_sel   = (region == RG_OVERLAY);
   assign bank_load = host_wr && sel_hit;
   assign ram_we    = host_wr && ram_sel;

   sbc_bank_reg #(.BANK_W(BANK_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .load(bank_load),
      .din(host_wdata[BANK_W-1:0]), .bank_q(bank_q)
   );

   sbc_overlay_ram #(.DATA_W(DATA_W), .WORDS(RAM_WORDS)) i_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
      .wdata(host_wdata), .rdata(ram_rdata)
   );

   if (FIXED_LOW) begin : g_fixed_low
      assign fixed_slot = '0;
      assign bank_slot  = SLOT_W'(bank_q) + SLOT_W'(1);
   end else begin : g_fixed_high
      assign fixed_slot = SLOT_W'(NUM_BANKS);
      assign bank_slot  = SLOT_W'(bank_q);
   end

   assign rom_addr = {(region == RG_BANKED) ? bank_slot : fixed_slot,
                      host_addr[OFS_W-1:0]};

   always_comb begin
      host_rdata = '0;
      if (ram_sel) begin
         host_rdata = ram_rdata;
      end else if (rom_cs) begin
         host_rdata = rom_rdata;
      end
   end

   assert_cs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs && ram_sel));

   assert_rom_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !ram_sel) |=> (bank_q == $past(bank_q)));

   assert_banked_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (region == RG_BANKED) |-> (rom_addr[ROM_AW-1:OFS_W] != fixed_slot));
endmodule

// File: tb/test_split_bank_ctrl.sv
module test_split_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_addr = 16'h0000;
   logic [7:0]  host_wdata = 8'h00;
   logic        host_wr = 1'b0;
   logic [7:0]  host_rdata;
   logic [14:0] rom_addr;
   logic [7:0]  rom_rdata;
   logic        rom_cs;
   logic        ram_sel;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [1:0] m_bank;
   logic [7:0] m_ram [1024];
   bit         m_valid [1024];

   always #2 clk = ~clk;

   function automatic logic [7:0] rom_fn(logic [14:0] a);
      return a[7:0] ^ {a[14:12], a[11:8], 1'b1} ^ 8'h5A;
   endfunction

   assign rom_rdata = rom_fn(rom_addr);

   split_bank_ctrl i_split_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rdata(host_rdata), .rom_addr(rom_addr),
      .rom_rdata(rom_rdata), .rom_cs(rom_cs), .ram_sel(ram_sel)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit in_win(logic [15:0] a);
      return a >= 16'h6000 && a <= 16'h7FFF;
   endfunction

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      if (a == 16'h6FFE) m_bank = d[1:0];
      if (a >= 16'h6C00 && a <= 16'h6FFF) begin
         m_ram[a[9:0]] = d;
         m_valid[a[9:0]] = 1'b1;
      end
   endtask

   task automatic do_read(input logic [15:0] a, input string req);
      logic [14:0] ea;
      @(negedge clk);
      host_addr = a; host_wr = 1'b0;
      #1;
      if (!in_win(a)) begin
         chk(!rom_cs && !ram_sel, req, {rom_cs, ram_sel}, 0);
         chk(host_rdata == 8'h00, req, host_rdata, 0);
      end else if (a >= 16'h7000) begin
         ea = {3'(m_bank) + 3'd1, a[11:0]};
         chk(rom_cs && !ram_sel, req, {rom_cs, ram_sel}, 2);
         chk(rom_addr == ea, req, rom_addr, ea);
         chk(host_rdata == rom_fn(ea), req, host_rdata, rom_fn(ea));
      end else if (a >= 16'h6C00) begin
         chk(ram_sel && !rom_cs, req, {rom_cs, ram_sel}, 1);
         if (m_valid[a[9:0]])
            chk(host_rdata == m_ram[a[9:0]], req, host_rdata, m_ram[a[9:0]]);
      end else begin
         ea = {3'b000, a[11:0]};
         chk(rom_cs && !ram_sel, req, {rom_cs, ram_sel}, 2);
         chk(rom_addr == ea, req, rom_addr, ea);
         chk(host_rdata == rom_fn(ea), req, host_rdata, rom_fn(ea));
      end
   endtask

   function automatic string tag_of(logic [15:0] a);
      if (!in_win(a)) return "R1";
      if (a >= 16'h7000) return "R3";
      if (a == 16'h6FFE) return "R7";
      if (a >= 16'h6C00) return "R6";
      return "R2";
   endfunction

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] a;
      logic [7:0]  d;
      void'($urandom(32'h5EED_0042));
      m_bank = 2'd0;
      for (int i = 0; i < 1024; i++) m_valid[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R5: reset bank is 0, so the banked half reaches slot 1
      do_read(16'h7123, "R5");
      do_read(16'h5FFF, "R1");
      do_read(16'h8000, "R1");
      do_read(16'h6000, "R2");
      do_read(16'h6BFF, "R2");

      // R4 and R7 on one edge: selection byte with nonzero upper bits
      do_write(16'h6FFE, 8'hA3);
      do_read(16'h7000, "R4");
      do_read(16'h6FFE, "R7");
      do_read(16'h6ABC, "R2");

      // R8: other overlay writes leave the bank alone
      do_write(16'h6C10, 8'h77);
      do_read(16'h7FFF, "R8");
      do_read(16'h6C10, "R8");

      // R9: ROM and outside writes touch nothing, including the alias 0x7FFE
      do_write(16'h7FFE, 8'h01);
      do_write(16'h6000, 8'h02);
      do_write(16'h9FFE, 8'h01);
      do_write(16'h5FFE, 8'h00);
      do_read(16'h7456, "R9");
      do_read(16'h6FFE, "R9");
      do_read(16'h6C10, "R9");

      // R4: every bank value, and back-to-back selection writes
      for (int b = 0; b < 4; b++) begin
         do_write(16'h6FFE, 8'(b) | 8'hFC);
         do_read(16'h7800, "R4");
      end
      do_write(16'h6FFE, 8'h01);
      do_write(16'h6FFE, 8'h02);
      do_read(16'h7001, "R4");
      do_read(16'h6FFE, "R7");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         case ($urandom_range(0, 5))
            0: begin
               a = 16'($urandom());
               if (in_win(a)) a = a ^ 16'h8000;
            end
            1: a = 16'h6000 + 16'($urandom_range(0, 16'h0BFF));
            2: a = 16'h6C00 + 16'($urandom_range(0, 16'h03FF));
            3: a = 16'h7000 + 16'($urandom_range(0, 16'h0FFF));
            default: a = ($urandom_range(0, 1) != 0) ? 16'h6FFE : 16'h7FFE;
         endcase
         d = 8'($urandom());
         if ($urandom_range(0, 1) != 0) begin
            do_write(a, d);
            do_read(16'h7000 + 16'($urandom_range(0, 16'h0FFF)), "R4");
         end else begin
            do_read(a, tag_of(a));
         end
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule